// File: doc/BRIEF.md
# Byte Serial Master with Write-Collision Flag

This block is a serial-peripheral master that moves one byte at a time. A processor writes a control register to pick the clock polarity, the clock phase, the bit rate and whether an interrupt is wanted. A write to the data register then starts an eight-bit exchange. The byte leaves on `mosi` most significant bit first, while eight bits are taken in from `miso`. When the exchange ends, the received byte becomes readable from the data register. A completion flag is raised, and it drives `irq` when interrupts are enabled.

The exchange is paced by a tick that marks each half bit. A three-phase sequencer steps on this tick through three phases: one tick opens the byte, and the ticks after it alternate between the start and the middle of each bit. A data write made while an exchange is under way does not disturb it. It sets a write-collision flag instead. Software clears flags in two steps. First it reads the status register, which marks the flags that are set at that moment. Then any data register read or write clears exactly those marked flags.

Register map (`busAddr`): 0 = control, 1 = status, 2 = data, 3 reads as zero.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset the control, status and data registers read 0x00, and `sck`, `mosi` and `irq` are 0.
- R2: A data write while idle starts an exchange of the written byte, MSB first. Each bit is taken from `miso` at mid-bit. The received byte reads back from address 2 once the exchange is complete, so with `miso` tied to `mosi` it equals the byte sent.
- R3: Control bits [4:3] select the half-bit tick period: 00 = 2, 01 = 4, 10 = 16 and 11 = 32 clock cycles. The completion flag is set exactly 17 tick periods after the clock edge that accepts the starting write.
- R4: Control bit 1 (polarity) sets the `sck` level while idle, and `sck` is back at that level when the exchange ends. Control bit 0 (phase) set to 1 gives 16 `sck` transitions per byte, the first one on the byte-opening tick. Phase set to 0 gives 14 transitions, none on the byte-opening tick.
- R5: A data write during an exchange sets status bit 6 (collision) and does not change the byte being sent.
- R6: Status bit 7 is the completion flag and status bit 0 shows an exchange in progress. `irq` equals the completion flag AND control bit 2 (interrupt enable).
- R7: A status read marks the flags that are set at that moment. The next data read or write clears the marked flags, and `irq` falls on the same clock edge.
- R8: A data access with no marked flags clears nothing, and a flag that is set after the marking status read survives the data access that follows.
- R9: The control register reads back its bits [4:0], and bits [7:5] read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register select |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a mix of marked and unmarked flags at the moment of a data access. The collision scenario gets there in a fixed order. It writes during an exchange, then reads status while the exchange is still running, which marks only the collision flag. It lets the completion flag rise afterwards and then reads data. At that point the collision flag must clear while the completion flag and `irq` stay set. A separate scenario starts a new exchange with a data write that is also the clearing access.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Sequencer phases; encoding fixed by the design
  typedef enum logic [1:0] {
    PH_BYTE = 2'd0,
    PH_BIT  = 2'd1,
    PH_MID  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [1:0] rate;
    logic       intEn;
    logic       cpol;
    logic       cpha;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic load;
    logic firstTick;
    logic sample;
    logic shift;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic              busy,
  output logic              doneFlag,
  output logic              colFlag
);
  localparam int CNT_W = $clog2(DATA_W) + 2;

  logic                    dataAcc, dataWr, statRd, ctrlWr, tick;
  logic [DIV_W-1:0]        divCnt, divLast;
  logic signed [CNT_W-1:0] bitCnt;
  phase_e                  phase;
  logic                    armDone, armCol;

  assign dataAcc = busSel && (busAddr == ADDR_DATA);
  assign dataWr  = dataAcc && busWrite;
  assign statRd  = busSel && !busWrite && (busAddr == ADDR_STAT);
  assign ctrlWr  = busSel && busWrite && (busAddr == ADDR_CTRL);

  always_comb begin
    unique case (cfg.rate)
      2'd0:    divLast = DIV_W'(1);
      2'd1:    divLast = DIV_W'(3);
      2'd2:    divLast = DIV_W'(15);
      default: divLast = DIV_W'(31);
    endcase
  end

  assign tick = busy && (divCnt == divLast);

  always_comb begin
    stb.load      = dataWr && !busy;
    stb.idle      = !busy && !stb.load;
    stb.firstTick = tick && (phase == PH_BYTE);
    stb.sample    = tick && (phase == PH_BIT);
    stb.shift     = tick && (phase == PH_MID);
    stb.finish    = stb.shift && (bitCnt < 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (ctrlWr) begin
      cfg <= cfg_t'(busWdata[4:0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      phase  <= PH_BYTE;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (stb.load) begin
      busy   <= 1'b1;
      phase  <= PH_BYTE;
      divCnt <= '0;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) begin
        unique case (phase)
          PH_BYTE: begin
            bitCnt <= CNT_W'(DATA_W - 1);
            phase  <= PH_BIT;
          end
          PH_BIT: begin
            bitCnt <= bitCnt - CNT_W'(1);
            phase  <= PH_MID;
          end
          default: begin
            phase <= PH_BIT;
            if (bitCnt < 0) busy <= 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      colFlag  <= 1'b0;
      armDone  <= 1'b0;
      armCol   <= 1'b0;
    end else begin
      doneFlag <= (doneFlag && !(dataAcc && armDone)) || stb.finish;
      colFlag  <= (colFlag && !(dataAcc && armCol)) || (dataWr && busy);
      if (statRd) begin
        armDone <= doneFlag;
        armCol  <= colFlag;
      end else if (dataAcc) begin
        armDone <= 1'b0;
        armCol  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_xfer_dp.sv
module spi_xfer_dp
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  cfg_t              cfg,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              miso,
  output logic              mosi,
  output logic              sck,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txShift, rxShift;
  logic              clkLvl;

  assign mosi = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxData  <= '0;
      clkLvl  <= 1'b0;
      sck     <= 1'b0;
    end else begin
      if (stb.load) begin
        txShift <= busWdata;
        // phase 0: pre-toggle so edges land mid-bit
        clkLvl  <= cfg.cpha ? cfg.cpol : !cfg.cpol;
      end else if (stb.idle) begin
        sck <= cfg.cpol;
      end else if (stb.firstTick) begin
        sck <= !clkLvl;
      end else if (stb.sample) begin
        rxShift <= {rxShift[DATA_W-2:0], miso};
        clkLvl  <= !clkLvl;
        sck     <= !clkLvl;
      end else if (stb.shift) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
        clkLvl  <= !clkLvl;
        sck     <= stb.finish ? cfg.cpol : !clkLvl;
      end
      if (stb.finish) rxData <= rxShift;
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  cfg_t              cfg;
  strobe_t           stb;
  logic              busy, doneFlag, colFlag;
  logic [DATA_W-1:0] rxData;

  spi_xfer_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .cfg(cfg), .stb(stb),
    .busy(busy), .doneFlag(doneFlag), .colFlag(colFlag)
  );

  spi_xfer_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .busWdata(busWdata),
    .miso(miso), .mosi(mosi), .sck(sck), .rxData(rxData)
  );

  assign irq = doneFlag && cfg.intEn;

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      unique case (busAddr)
        ADDR_CTRL: busRdata = DATA_W'(cfg);
        ADDR_STAT: busRdata = DATA_W'({doneFlag, colFlag, 5'b0, busy});
        ADDR_DATA: busRdata = rxData;
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk
  import spi_xfer_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWrite,
  input logic [1:0] busAddr,
  input cfg_t       cfg,
  input logic       busy,
  input logic       doneFlag,
  input logic       colFlag,
  input logic       sck
);
  logic dataAcc, dataWr;
  assign dataAcc = busSel && (busAddr == ADDR_DATA);
  assign dataWr  = dataAcc && busWrite;

  a_r2_write_starts: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !busy) |=> busy);

  a_r5_write_collides: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && busy) |=> colFlag);

  a_r4_sck_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy) && $stable(cfg.cpol)) |-> (sck == cfg.cpol));

  a_r6_done_needs_xfer: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(busy));

  a_r6_end_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  a_r8_flag_kept: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !dataAcc) |=> doneFlag);
endmodule

bind spi_xfer_master spi_xfer_chk chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .cfg(cfg), .busy(busy), .doneFlag(doneFlag),
  .colFlag(colFlag), .sck(sck)
);

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sck, mosi, miso, irq;
  logic       loopMode = 1'b1, misoVal = 1'b0;
  int         tests = 0, fails = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;
  assign miso = loopMode ? mosi : misoVal;

  spi_xfer_master dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic waitIrq(output int cyc, output int edges);
    logic prev;
    cyc = 0; edges = 0; prev = sck;
    while (!irq && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (sck !== prev) edges++;
      prev = sck;
    end
  endtask

  task automatic tReset();
    logic [7:0] d;
    chk("R1 sck", sck, 0); chk("R1 mosi", mosi, 0); chk("R1 irq", irq, 0);
    busRd(0, d); chk("R1 ctrl", d, 0);
    busRd(1, d); chk("R1 status", d, 0);
    busRd(2, d); chk("R1 data", d, 0);
  endtask

  task automatic tCtrl();
    logic [7:0] d;
    busWr(0, 8'hFF); busRd(0, d); chk("R9 ctrl mask", d, 8'h1F);
    busWr(0, 8'h0A); busRd(0, d); chk("R9 ctrl value", d, 8'h0A);
    busWr(0, 8'h00);
  endtask

  task automatic tXfer(logic [1:0] rate, logic cpol, logic cpha, logic [7:0] tx,
                       logic lp, logic mv, logic [7:0] expRx);
    logic [7:0] d;
    int cyc, edges, ratio;
    ratio = (rate == 0) ? 2 : (rate == 1) ? 4 : (rate == 2) ? 16 : 32;
    loopMode = lp; misoVal = mv;
    busWr(0, {3'b0, rate, 1'b1, cpol, cpha});
    busWr(2, tx);
    waitIrq(cyc, edges);
    chk("R3 duration", cyc, 17 * ratio);
    chk("R4 sck edges", edges, cpha ? 16 : 14);
    chk("R4 sck end level", sck, cpol);
    busRd(1, d); chk("R6 status done", d, 8'h80);
    busRd(2, d); chk("R2 rx byte", d, expRx);
    chk("R7 irq cleared", irq, 0);
    busRd(1, d); chk("R7 status cleared", d, 8'h00);
  endtask

  task automatic tCollision();
    logic [7:0] d;
    int cyc, edges;
    loopMode = 1;
    busWr(0, 8'h0C);            // rate 01, irq enabled, cpol 0, cpha 0
    busWr(2, 8'h96);
    repeat (3) @(negedge clk);
    busWr(2, 8'h11);
    busRd(1, d); chk("R5 collision flag", d, 8'h41);
    waitIrq(cyc, edges);
    busRd(2, d); chk("R5 byte unchanged", d, 8'h96);
    chk("R8 irq kept", irq, 1);
    busRd(1, d); chk("R8 done survives", d, 8'h80);
    busRd(2, d);
    busRd(1, d); chk("R7 done cleared", d, 8'h00);
  endtask

  task automatic tNoArm();
    logic [7:0] d;
    int cyc, edges;
    loopMode = 1;
    busWr(0, 8'h05);            // rate 00, irq enabled, cpha 1
    busWr(2, 8'hC3);
    waitIrq(cyc, edges);
    busRd(2, d); chk("R2 rx loop", d, 8'hC3);
    chk("R8 no clear without status", irq, 1);
    busRd(1, d);
    busWr(2, 8'h5A);            // clears marked flag and starts again
    chk("R7 write clears irq", irq, 0);
    busRd(1, d); chk("R7 write clears and starts", d, 8'h01);
    waitIrq(cyc, edges);
    busRd(1, d); busRd(2, d); chk("R2 second byte", d, 8'h5A);
  endtask

  task automatic tIrqMask();
    logic [7:0] d;
    busWr(0, 8'h01);            // irq disabled
    busWr(2, 8'h77);
    repeat (40) @(negedge clk);
    chk("R6 irq masked", irq, 0);
    busRd(1, d); chk("R6 done without irq", d, 8'h80);
    busRd(2, d);
    busWr(0, 8'h05);
    chk("R6 irq follows enable", irq, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCtrl();
    tXfer(2'd0, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0, 8'hA5);
    tXfer(2'd1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0, 8'h3C);
    tXfer(2'd3, 1'b0, 1'b0, 8'h12, 1'b0, 1'b1, 8'hFF);
    tXfer(2'd2, 1'b1, 1'b1, 8'hE7, 1'b0, 1'b0, 8'h00);
    tCollision();
    tNoArm();
    tIrqMask();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule